// File: doc/BRIEF.md
# BCD Calendar Counter with Masked Alarm

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year. A prescaler counts pulses of a 32.768 kHz tick input and produces a once-per-second advance. Each advance steps the seconds, and carries ripple into the higher fields within the same clock edge. Day-of-month limits follow the month, and the leap rule is year mod 4, with year 00 counted as a leap year. A write-enabled byte bus reaches every field, the control byte, the alarm bytes and a status byte.

The register map uses byte addresses. Address 0 is control: bit 0 is run/write-enable, bit 1 is test stepping and bit 2 is prescaler clear. Addresses 1 to 6 hold the time fields: seconds, minutes, hours, date, month, year. Address 7 is alarm control: bits 0 to 5 are per-field match enables in that same field order, and bit 6 is the global alarm enable. Addresses 8 to 13 are the alarm fields in the same order. Address 14 is status, with bit 0 as the alarm-pending flag, cleared by writing 1. Reads are combinational from the address.

Top module: `rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, date 01, month 01, year 00. Control, alarm control, all alarm fields and status read 0, and irq_o is low.
- R2: Seconds advance by one once every TICKS_PER_SEC pulses of tick_i, in packed BCD. Seconds and minutes run 00..59 and hours run 00..23, with the digit carry 09->10 inside each byte.
- R3: All carries from seconds through year take effect on the same clock edge. Date wraps to 01 after 28, 29, 30 or 31 according to month and leap year (year mod 4 == 0, 00 included). Month wraps 12->01 and year wraps 99->00.
- R4: Writes to addresses 1..6 are accepted only while control bit 0 is 1. Otherwise they leave the time unchanged. An accepted time write suppresses the advance in that cycle.
- R5: While control bit 2 is 1 the prescaler is held at zero and no advance occurs. Once the bit clears, the next advance comes TICKS_PER_SEC ticks later.
- R6: While control bit 1 is 1, every time field steps by one on each tick_i pulse, each wrapping at its own limit, with no carries between fields.
- R7: After an advance, the alarm fires if every field whose enable bit (address 7, bits 0..5) is set equals its alarm byte. Fields with clear enable bits are ignored. Firing sets status bit 0 one clock later, and irq_o follows that bit.
- R8: With alarm-control bit 6 clear, no match sets the pending flag.
- R9: Writing status with bit 0 = 1 clears the pending flag. Writing 0 leaves it set. A new firing in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| irq_o | output | 1 | Alarm interrupt, level, equals pending flag |

## Verification
The bench drives full-year rollover from 23:59:59 on 31 Dec of year 99. A design with a staged carry would show a partially updated date, or a year stuck at 99. It steps the end of February in years 01, 04 and 00, and the end of April. A wrong leap rule would either skip 29 Feb or produce it in a common year. It writes the time while writes are locked, holds the prescaler clear, and steps in test mode from fields that sit at their limits, so that any leaked carry shows up. The alarm is exercised with seconds-only matching, with a mismatching enabled minute, and with the global enable off, as well as zero and one writes to the pending flag. A design that compared masked fields, ignored the global enable or cleared on a zero write would show a wrong irq_o.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int NF = 6;  // sec, min, hour, date, month, year

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_TIME0  = 4'd1;
  localparam logic [3:0] A_TIME5  = 4'd6;
  localparam logic [3:0] A_ALMCTL = 4'd7;
  localparam logic [3:0] A_ALM0   = 4'd8;
  localparam logic [3:0] A_ALM5   = 4'd13;
  localparam logic [3:0] A_STAT   = 4'd14;

  localparam int CTL_RUN  = 0;
  localparam int CTL_TEST = 1;
  localparam int CTL_CLR  = 2;
  localparam int ALM_GEN  = 6;

  // One BCD step with wrap from top back to base
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] base);
    if (v >= top) return base;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [6:0] b;
    b = {3'b000, y[7:4]} * 7'd10 + {3'b000, y[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m,
                                          input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
`timescale 1ns/1ps
module rtc_tick_div #(
  parameter int unsigned TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clr_i,
  output logic strobe_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign strobe_o = tick_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)            cnt_q <= '0;  // R5 hold at zero
    else if (tick_i)                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv_i,
  input  logic                 step_all_i,
  input  logic [NF-1:0]        wr_sel_i,
  input  logic [7:0]           wr_data_i,
  output logic [NF-1:0][7:0]   field_o,
  output logic [NF-2:0]        carry_o
);
  logic [NF-1:0][7:0] f_q;
  logic [NF-1:0][7:0] top_v;
  logic [NF-1:0][7:0] base_v;
  logic [NF-1:0]      wrap;
  logic [NF-1:0]      en;

  always_comb begin
    top_v[0] = 8'h59;
    top_v[1] = 8'h59;
    top_v[2] = 8'h23;
    top_v[3] = last_day(f_q[4], f_q[5]);   // R3 month/leap limit
    top_v[4] = 8'h12;
    top_v[5] = 8'h99;
    base_v   = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  end

  assign en[0] = adv_i;

  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_fld
      assign wrap[i] = (f_q[i] >= top_v[i]);
      if (i > 0) begin : g_en
        // R6 independent stepping in test mode, R3 carry otherwise
        assign en[i] = step_all_i ? adv_i : carry_o[i-1];
      end
      if (i < NF-1) begin : g_cy
        if (i == 0) begin : g_c0
          assign carry_o[i] = adv_i && !step_all_i && wrap[i];
        end else begin : g_cn
          assign carry_o[i] = carry_o[i-1] && wrap[i];
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n)            f_q[i] <= base_v[i];
        else if (wr_sel_i[i])  f_q[i] <= wr_data_i;
        else if (en[i])        f_q[i] <= bcd_step(f_q[i], top_v[i], base_v[i]);
      end
    end
  endgenerate

  assign field_o = f_q;
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
  import rtc_pkg::*;
(
  input  logic               eval_i,
  input  logic               gen_i,
  input  logic [NF-1:0]      fen_i,
  input  logic [NF-1:0][7:0] time_i,
  input  logic [NF-1:0][7:0] alm_i,
  output logic [NF-1:0]      match_o,
  output logic               hit_o
);
  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_cmp
      assign match_o[i] = !fen_i[i] || (time_i[i] == alm_i[i]);  // R7 mask
    end
  endgenerate

  assign hit_o = eval_i && gen_i && (&match_o);  // R8 global gate
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       bus_wr_i,
  input  logic [3:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       irq_o
);
  logic [2:0]         ctrl_q;
  logic [6:0]         almctl_q;
  logic [NF-1:0][7:0] alm_q;
  logic               pend_q;
  logic               adv_d_q;

  logic               sec_strobe;
  logic               adv;
  logic               time_wr;
  logic [NF-1:0]      wr_sel;
  logic [NF-1:0][7:0] time_q;
  logic [NF-2:0]      carry;
  logic [NF-1:0]      match;
  logic               hit;
  logic               in_time, in_alm, stat_w1c;
  logic [3:0]         t_idx, a_idx;

  assign in_time  = (bus_addr_i >= A_TIME0) && (bus_addr_i <= A_TIME5);
  assign in_alm   = (bus_addr_i >= A_ALM0)  && (bus_addr_i <= A_ALM5);
  assign t_idx    = bus_addr_i - A_TIME0;
  assign a_idx    = bus_addr_i - A_ALM0;
  assign time_wr  = bus_wr_i && in_time && ctrl_q[CTL_RUN];         // R4
  assign stat_w1c = bus_wr_i && (bus_addr_i == A_STAT) && bus_wdata_i[0];

  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_sel
      assign wr_sel[i] = time_wr && (t_idx == 4'(i));
    end
  endgenerate

  rtc_tick_div #(.TICKS(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .clr_i(ctrl_q[CTL_CLR]), .strobe_o(sec_strobe)
  );

  // R5 clear blocks stepping, R6 test steps on raw ticks, R4 write wins
  assign adv = (ctrl_q[CTL_TEST] ? tick_i : sec_strobe)
               && !ctrl_q[CTL_CLR] && !time_wr;

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .step_all_i(ctrl_q[CTL_TEST]),
    .wr_sel_i(wr_sel), .wr_data_i(bus_wdata_i),
    .field_o(time_q), .carry_o(carry)
  );

  rtc_alarm_match u_alm (
    .eval_i(adv_d_q), .gen_i(almctl_q[ALM_GEN]), .fen_i(almctl_q[NF-1:0]),
    .time_i(time_q), .alm_i(alm_q), .match_o(match), .hit_o(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      almctl_q <= '0;
      alm_q    <= '0;
      pend_q   <= 1'b0;
      adv_d_q  <= 1'b0;
    end else begin
      adv_d_q <= adv;
      if (bus_wr_i && bus_addr_i == A_CTRL)   ctrl_q   <= bus_wdata_i[2:0];
      if (bus_wr_i && bus_addr_i == A_ALMCTL) almctl_q <= bus_wdata_i[6:0];
      if (bus_wr_i && in_alm)                 alm_q[a_idx[2:0]] <= bus_wdata_i;
      if (hit)           pend_q <= 1'b1;   // R9 set wins
      else if (stat_w1c) pend_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = 8'h00;
    if (bus_addr_i == A_CTRL)        bus_rdata_o = {5'b0, ctrl_q};
    else if (in_time)                bus_rdata_o = time_q[t_idx[2:0]];
    else if (bus_addr_i == A_ALMCTL) bus_rdata_o = {1'b0, almctl_q};
    else if (in_alm)                 bus_rdata_o = alm_q[a_idx[2:0]];
    else if (bus_addr_i == A_STAT)   bus_rdata_o = {7'b0, pend_q};
  end

  assign irq_o = pend_q;  // R7
endmodule

// File: rtl/rtc_core_checker.sv
`timescale 1ns/1ps
module rtc_core_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        ctrl_run,
  input logic        ctrl_clr,
  input logic        step_all,
  input logic        strobe,
  input logic        adv,
  input logic        time_wr,
  input logic        hit,
  input logic        gen,
  input logic [47:0] tm,
  input logic        irq
);
  assert_divclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr |-> !strobe);

  assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !ctrl_run && bus_addr >= 4'd1 && bus_addr <= 4'd6 && !adv)
    |=> $stable(tm));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !time_wr) |=> $stable(tm));

  assert_same_edge_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !step_all && tm[7:0] == 8'h59) |=> (tm[15:8] != $past(tm[15:8])));

  assert_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq);

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(gen));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd14 && bus_wdata[0] && !hit) |=> !irq);
endmodule

bind rtc_core rtc_core_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
  .bus_wdata(bus_wdata_i), .ctrl_run(ctrl_q[0]), .ctrl_clr(ctrl_q[2]),
  .step_all(ctrl_q[1]), .strobe(sec_strobe), .adv(adv), .time_wr(time_wr),
  .hit(hit), .gen(almctl_q[6]), .tm(time_q), .irq(irq_o)
);

// File: tb/rtc_core_test.sv
`timescale 1ns/1ps
module rtc_core_test;
  localparam int unsigned TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [3:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rtc_core #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, d, mo, y);
    wr(4'd0, 8'h05);               // run + prescaler clear
    wr(4'd1, s); wr(4'd2, mi); wr(4'd3, h);
    wr(4'd4, d); wr(4'd5, mo); wr(4'd6, y);
    wr(4'd0, 8'h01);
  endtask

  task automatic chk_time(input string req, input logic [7:0] s, mi, h, d, mo, y);
    rchk(req, 4'd1, s); rchk(req, 4'd2, mi); rchk(req, 4'd3, h);
    rchk(req, 4'd4, d); rchk(req, 4'd5, mo); rchk(req, 4'd6, y);
  endtask

  task automatic t_reset;
    chk_time("R1 reset time", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    rchk("R1 reset ctrl", 4'd0, 8'h00);
    rchk("R1 reset almctl", 4'd7, 8'h00);
    for (int a = 8; a <= 13; a++) rchk("R1 reset alarm", 4'(a), 8'h00);
    rchk("R1 reset status", 4'd14, 8'h00);
    chk("R1 reset irq", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_seconds;
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    ticks(TPS - 1);
    rchk("R2 before full second", 4'd1, 8'h10);
    ticks(1);
    rchk("R2 one second", 4'd1, 8'h11);
    set_time(8'h59, 8'h59, 8'h09, 8'h15, 8'h07, 8'h30);
    ticks(TPS);
    chk_time("R2 hour digit carry", 8'h00, 8'h00, 8'h10, 8'h15, 8'h07, 8'h30);
  endtask

  task automatic t_rollover;
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    ticks(TPS);
    chk_time("R3 full rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01);
    ticks(TPS);
    rchk("R3 common Feb date", 4'd4, 8'h01); rchk("R3 common Feb month", 4'd5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h04);
    ticks(TPS);
    rchk("R3 leap Feb date", 4'd4, 8'h29); rchk("R3 leap Feb month", 4'd5, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h00);
    ticks(TPS);
    rchk("R3 year00 Feb date", 4'd4, 8'h01); rchk("R3 year00 Feb month", 4'd5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h23);
    ticks(TPS);
    rchk("R3 April end date", 4'd4, 8'h01); rchk("R3 April end month", 4'd5, 8'h05);
  endtask

  task automatic t_locked;
    set_time(8'h20, 8'h11, 8'h05, 8'h03, 8'h03, 8'h12);
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h33);
    wr(4'd6, 8'h77);
    rchk("R4 locked sec", 4'd1, 8'h20);
    rchk("R4 locked year", 4'd6, 8'h12);
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h33);
    rchk("R4 unlocked sec", 4'd1, 8'h33);
  endtask

  task automatic t_divclr;
    set_time(8'h40, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    wr(4'd0, 8'h05);
    ticks(3 * TPS);
    rchk("R5 held clear", 4'd1, 8'h40);
    wr(4'd0, 8'h01);
    ticks(TPS - 1);
    rchk("R5 restart partial", 4'd1, 8'h40);
    ticks(1);
    rchk("R5 restart full", 4'd1, 8'h41);
  endtask

  task automatic t_test_mode;
    set_time(8'h59, 8'h05, 8'h23, 8'h31, 8'h12, 8'h99);
    wr(4'd0, 8'h03);
    ticks(1);
    chk_time("R6 test step", 8'h00, 8'h06, 8'h00, 8'h01, 8'h01, 8'h00);
    ticks(1);
    chk_time("R6 test step again", 8'h01, 8'h07, 8'h01, 8'h02, 8'h02, 8'h01);
    wr(4'd0, 8'h01);
  endtask

  task automatic t_alarm;
    wr(4'd8, 8'h05);
    wr(4'd9, 8'h31);
    wr(4'd7, 8'h41);                        // sec only + global
    set_time(8'h03, 8'h30, 8'h12, 8'h15, 8'h06, 8'h24);
    ticks(TPS); @(negedge clk);
    chk("R7 no match yet", {7'b0, irq_o}, 8'h00);
    ticks(TPS); @(negedge clk);
    chk("R7 sec-only fire irq", {7'b0, irq_o}, 8'h01);
    rchk("R7 pending status", 4'd14, 8'h01);
    wr(4'd14, 8'h00);
    rchk("R9 zero write keeps", 4'd14, 8'h01);
    wr(4'd14, 8'h01);
    rchk("R9 w1c clears", 4'd14, 8'h00);
    chk("R9 irq low", {7'b0, irq_o}, 8'h00);
    wr(4'd7, 8'h01);                        // global off
    set_time(8'h04, 8'h30, 8'h12, 8'h15, 8'h06, 8'h24);
    ticks(TPS); @(negedge clk);
    rchk("R8 gated sec", 4'd1, 8'h05);
    chk("R8 global off", {7'b0, irq_o}, 8'h00);
    wr(4'd7, 8'h43);                        // sec+min + global, min mismatch
    set_time(8'h04, 8'h30, 8'h12, 8'h15, 8'h06, 8'h24);
    ticks(TPS); @(negedge clk);
    chk("R7 enabled min mismatch", {7'b0, irq_o}, 8'h00);
    wr(4'd9, 8'h30);
    set_time(8'h04, 8'h30, 8'h12, 8'h15, 8'h06, 8'h24);
    ticks(TPS); @(negedge clk);
    chk("R7 sec+min match", {7'b0, irq_o}, 8'h01);
    wr(4'd14, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_rollover();
    t_locked();
    t_divclr();
    t_test_mode();
    t_alarm();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule